// File: doc/BRIEF.md
# Permission-Checking Address Translation Cache

This block is a small, fully associative translation cache between a processor's load/store unit and its physical memory. A lookup presents a virtual address, an address-space identifier, the access kind (read or write) and the privilege level (kernel or user). All stored translations are compared at once. If one matches, the physical frame number is joined to the untouched page offset. If the stored rights forbid the access, a protection fault is reported instead. If nothing matches, a miss is reported so that an external page-table walker can fetch the translation.

The walker installs translations through a refill port. The victim is chosen by a reference-bit scheme:
- an entry's bit is set each time it serves a successful lookup;
- an aging pulse clears all the bits;
- a refill prefers empty entries, then entries whose bit is clear, and otherwise falls back to a rotating pointer.

A flush port removes either every translation or only those of one address space. Because each entry is tagged with its address space, nothing has to be flushed when the processor changes context.

Top module: `perm_tlb`

## Requirements
- R1: The cache holds 40 entries (parameter), and any translation can sit in any entry; 40 translations with distinct keys, installed after reset with no flush, all remain resident and hit.
- R2: On a hit, `res_paddr` is the stored frame number in bits [31:12] with the lookup's low 12 address bits copied unchanged (4 KiB pages, 32-bit addresses); when there is no hit, `res_paddr` is zero.
- R3: An entry matches only when both the virtual page number and the address-space identifier are equal; the same page under another identifier misses, and both translations can be resident together.
- R4: The permission field has bit 0 for kernel read, bit 1 for kernel write, bit 2 for user read and bit 3 for user write. A matching entry whose bit for the access (`lk_user`, `lk_write`) is 0 raises `res_fault` and gives no translation.
- R5: The outputs are combinational in the same cycle as `lk_valid`. Exactly one of `res_hit`, `res_miss` and `res_fault` is 1 while `lk_valid` is 1, and all three are 0 while it is 0.
- R6: A refill with no matching entry writes the lowest-indexed invalid entry if one exists.
- R7: A successful hit sets that entry's reference bit. When all entries are valid, a refill replaces the lowest-indexed entry whose reference bit is clear. A freshly written entry starts with its bit clear.
- R8: When all entries are valid with their reference bits set, a refill replaces the entry at a rotating pointer (0 after reset, advancing by one and wrapping from 39 to 0). It then clears every reference bit.
- R9: `age_pulse` clears every reference bit at the clock edge. A hit in the same cycle still sets its own bit.
- R10: `flush_valid` invalidates every entry, or only entries whose identifier equals `flush_asid` when `flush_by_asid` is 1. A refill in the same cycle is dropped.
- R11: A refill whose page number and identifier match a resident entry overwrites that entry in place.
- R12: After reset, no entry is valid, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_user | input | 1 | 1 for user mode, 0 for kernel mode |
| res_hit | output | 1 | Translation found and permitted |
| res_miss | output | 1 | No matching entry |
| res_fault | output | 1 | Matching entry forbids the access |
| res_paddr | output | 32 | Translated physical address, zero unless hit |
| fill_valid | input | 1 | Install a translation at the clock edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asid | input | 8 | Identifier of the installed translation |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 4 | Rights: bit0 kernel read, bit1 kernel write, bit2 user read, bit3 user write |
| flush_valid | input | 1 | Invalidate entries at the clock edge |
| flush_by_asid | input | 1 | Restrict the flush to one identifier |
| flush_asid | input | 8 | Identifier to flush when restricted |
| age_pulse | input | 1 | Clear all reference bits |

## Verification
The bench fills all 40 entries and then forces replacement in each of its three regimes: an empty entry available, a clear reference bit available, and every bit set. A wrong choice evicts a translation that the model still expects to hit, so the error shows up as an unexpected miss. It also walks all four privilege and access combinations against single-bit permission patterns. A swapped bit map would return a translation where a fault is due. The remaining targets are a flush restricted to one identifier, refills colliding with flushes, repeated refills of a resident key, and aging pulses landing on hit cycles. A design that flushed too widely, created duplicate entries or lost the reference bit of a hit would diverge from the model on the next lookup of that page.

// File: rtl/tlb_pkg.sv
// Shared encodings for the translation cache.
// Assumes a 4-bit permission field indexed by {user, write}.
package tlb_pkg;

    localparam int PERM_W = 4;

    // Source that supplied the refill victim, in priority order.
    typedef enum logic [1:0] {
        VIC_DUP    = 2'd0,
        VIC_FREE   = 2'd1,
        VIC_COLD   = 2'd2,
        VIC_ROTATE = 2'd3
    } victim_src_e;

    // Index of the permission bit for a given mode and access kind.
    function automatic logic [1:0] perm_sel(input logic user, input logic write);
        return {user, write};
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel key comparator: compares one key against every stored key.
// Assumes at most one valid entry matches (refill overwrites duplicates).
module tlb_match #(
    parameter int N     = 40,
    parameter int KEY_W = 28,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [KEY_W-1:0] keys [N],
    input  logic [KEY_W-1:0] probe,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] hit_vec;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (keys[g] == probe);
    end

    // Encode the matching position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |hit_vec;

endmodule

// File: rtl/tlb_victim.sv
// Refill slot selection: duplicate key, then lowest invalid, then lowest
// entry with a clear reference bit, else the rotating pointer.
// Assumes ptr is always below N.
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N = 40,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     refd,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] idx,
    output victim_src_e      src
);

    logic [IDX_W-1:0] free_idx, cold_idx;
    logic             free_any, cold_any;

    // Lowest-index free entry and lowest-index unreferenced entry.
    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        free_any = 1'b0;
        cold_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
            if (!refd[i]) begin
                cold_idx = IDX_W'(i);
                cold_any = 1'b1;
            end
        end
    end

    // Priority choice among the candidates.
    always_comb begin
        if (dup_any) begin
            idx = dup_idx;
            src = VIC_DUP;
        end else if (free_any) begin
            idx = free_idx;
            src = VIC_FREE;
        end else if (cold_any) begin
            idx = cold_idx;
            src = VIC_COLD;
        end else begin
            idx = ptr;
            src = VIC_ROTATE;
        end
    end

endmodule

// File: rtl/perm_tlb.sv
// Fully associative translation cache with address-space tags, per-mode
// read/write rights and reference-bit replacement. Lookups resolve in the
// same cycle; refill, flush and aging take effect at the clock edge.
// Assumes the walker never refills while a flush is pending in the same cycle
// expecting both to apply (flush wins).
module perm_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 40,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PFN_W  = PA_W - OFS_W,
    localparam int KEY_W  = ASID_W + VPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_fault,
    output logic [PA_W-1:0]   res_paddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_valid,
    input  logic              flush_by_asid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              age_pulse
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [KEY_W-1:0]  key_q  [ENTRIES];
    logic [PFN_W-1:0]  pfn_q  [ENTRIES];
    logic [PERM_W-1:0] perm_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q, ref_q;
    logic [IDX_W-1:0]  ptr_q;

    logic              lk_any, dup_any, perm_ok;
    logic [IDX_W-1:0]  lk_idx, dup_idx, vic_idx;
    victim_src_e       vic_src;

    tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
        .valid (valid_q),
        .keys  (key_q),
        .probe ({lk_asid, lk_vaddr[VA_W-1:OFS_W]}),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_fill_match (
        .valid (valid_q),
        .keys  (key_q),
        .probe ({fill_asid, fill_vpn}),
        .any   (dup_any),
        .idx   (dup_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid   (valid_q),
        .refd    (ref_q),
        .dup_any (dup_any),
        .dup_idx (dup_idx),
        .ptr     (ptr_q),
        .idx     (vic_idx),
        .src     (vic_src)
    );

    // Lookup result: permission check and address assembly.
    always_comb begin
        perm_ok   = perm_q[lk_idx][perm_sel(lk_user, lk_write)];
        res_hit   = lk_valid && lk_any && perm_ok;
        res_fault = lk_valid && lk_any && !perm_ok;
        res_miss  = lk_valid && !lk_any;
        res_paddr = res_hit ? {pfn_q[lk_idx], lk_vaddr[OFS_W-1:0]} : '0;
    end

    // Validity, reference bits and rotating pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            ptr_q   <= '0;
        end else begin
            if (age_pulse) ref_q <= '0;
            if (res_hit) ref_q[lk_idx] <= 1'b1;
            if (flush_valid) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (!flush_by_asid || key_q[i][KEY_W-1:VPN_W] == flush_asid) begin
                        valid_q[i] <= 1'b0;
                        ref_q[i]   <= 1'b0;
                    end
                end
            end else if (fill_valid) begin
                if (vic_src == VIC_ROTATE) begin
                    ref_q <= '0;
                    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
                end
                valid_q[vic_idx] <= 1'b1;
                ref_q[vic_idx]   <= 1'b0;
            end
        end
    end

    // Entry payload, written on an accepted refill.
    always_ff @(posedge clk) begin
        if (fill_valid && !flush_valid) begin
            key_q[vic_idx]  <= {fill_asid, fill_vpn};
            pfn_q[vic_idx]  <= fill_pfn;
            perm_q[vic_idx] <= fill_perm;
        end
    end

endmodule

// File: rtl/perm_tlb_checker.sv
// Property checker for perm_tlb, attached by bind. Observes ports only.
module perm_tlb_checker #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFS_W  = 12,
    parameter int ASID_W = 8,
    localparam int VPN_W = VA_W - OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic              flush_valid,
    input logic              flush_by_asid,
    input logic              res_hit,
    input logic              res_miss,
    input logic              res_fault,
    input logic [PA_W-1:0]   res_paddr
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({res_hit, res_miss, res_fault}) == 1); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(res_hit || res_miss || res_fault)); // R5

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R2

    AST_NO_ADDR_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_paddr == '0); // R2

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_by_asid) |=> !(res_hit || res_fault)); // R10

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_valid) |=>
        ((lk_valid && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn) && lk_asid == $past(fill_asid))
         -> !res_miss)); // R11

endmodule

bind perm_tlb perm_tlb_checker #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ASID_W(ASID_W)
) u_perm_tlb_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .flush_valid(flush_valid), .flush_by_asid(flush_by_asid),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault), .res_paddr(res_paddr)
);

// File: tb/test_perm_tlb.sv
// Bench for perm_tlb: behavioural reference model compared every cycle.
module test_perm_tlb;

    localparam int N = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        res_hit, res_miss, res_fault;
    logic [31:0] res_paddr;
    logic        fill_valid = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [7:0]  fill_asid = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush_valid = 0, flush_by_asid = 0, age_pulse = 0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int errors = 0;
    string tag = "R12";

    // reference model state
    bit      m_valid [N];
    bit      m_ref   [N];
    int      m_vpn   [N];
    int      m_asid  [N];
    int      m_pfn   [N];
    int      m_perm  [N];
    int      m_ptr;
    int      e_idx;
    bit      e_hit, e_miss, e_fault;
    logic [31:0] e_paddr;

    always #10 clk = ~clk;

    perm_tlb i_perm_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_user(lk_user),
        .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
        .res_paddr(res_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_valid(flush_valid), .flush_by_asid(flush_by_asid),
        .flush_asid(flush_asid), .age_pulse(age_pulse)
    );

    // Expected lookup outcome from the model and current inputs.
    task automatic predict();
        e_idx = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == int'(lk_vaddr[31:12]) && m_asid[i] == int'(lk_asid))
                e_idx = i;
        e_hit = 0; e_miss = 0; e_fault = 0; e_paddr = '0;
        if (lk_valid) begin
            if (e_idx < 0) e_miss = 1;
            else if (m_perm[e_idx][{lk_user, lk_write}]) begin
                e_hit = 1;
                e_paddr = {m_pfn[e_idx][19:0], lk_vaddr[11:0]};
            end else e_fault = 1;
        end
    endtask

    // Apply the clock-edge effects to the model.
    task automatic model_edge();
        int vic = -1;
        bit rot = 0;
        for (int i = 0; i < N && vic < 0; i++)
            if (m_valid[i] && m_vpn[i] == int'(fill_vpn) && m_asid[i] == int'(fill_asid)) vic = i;
        for (int i = 0; i < N && vic < 0; i++) if (!m_valid[i]) vic = i;
        for (int i = 0; i < N && vic < 0; i++) if (!m_ref[i]) vic = i;
        if (vic < 0) begin vic = m_ptr; rot = 1; end
        if (age_pulse) for (int i = 0; i < N; i++) m_ref[i] = 0;
        if (e_hit) m_ref[e_idx] = 1;
        if (flush_valid) begin
            for (int i = 0; i < N; i++)
                if (!flush_by_asid || m_asid[i] == int'(flush_asid)) begin
                    m_valid[i] = 0; m_ref[i] = 0;
                end
        end else if (fill_valid) begin
            if (rot) begin
                for (int i = 0; i < N; i++) m_ref[i] = 0;
                m_ptr = (m_ptr + 1) % N;
            end
            m_valid[vic] = 1; m_ref[vic] = 0;
            m_vpn[vic] = int'(fill_vpn); m_asid[vic] = int'(fill_asid);
            m_pfn[vic] = int'(fill_pfn); m_perm[vic] = int'(fill_perm);
        end
    endtask

    // One cycle: inputs already set; compare mid-cycle, then advance.
    task automatic step();
        #5;
        predict();
        checks++;
        if ({res_hit, res_miss, res_fault} != {e_hit, e_miss, e_fault} || res_paddr !== e_paddr) begin
            errors++;
            $display("FAIL %s hit/miss/fault=%b%b%b paddr=%h expected %b%b%b paddr=%h",
                     tag, res_hit, res_miss, res_fault, res_paddr, e_hit, e_miss, e_fault, e_paddr);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; flush_valid = 0; age_pulse = 0;
    endtask

    task automatic look(input int vpn, input int asid, input bit user, input bit wr);
        lk_valid = 1; lk_vaddr = {vpn[19:0], 12'($urandom)};
        lk_asid = asid[7:0]; lk_user = user; lk_write = wr;
    endtask

    task automatic fill(input int vpn, input int asid, input int pfn, input int perm);
        fill_valid = 1; fill_vpn = vpn[19:0]; fill_asid = asid[7:0];
        fill_pfn = pfn[19:0]; fill_perm = perm[3:0];
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_ref[i] = 0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R12: idle outputs and a miss after reset
        tag = "R12"; step();
        look(5, 1, 0, 0); step();
        // R1 and R2: fill every entry, then translate all of them
        tag = "R1";
        for (int i = 0; i < N; i++) begin fill(256 + i, 1, 4096 + 7 * i, 15); step(); end
        tag = "R2";
        for (int i = 0; i < N; i++) begin look(256 + i, 1, i[0], i[1]); step(); end
        // R4: single-bit rights, each mode and access kind
        tag = "R4";
        for (int p = 0; p < 4; p++) begin
            tag = "R11"; fill(256, 1, 777 + p, 1 << p); step();
            tag = "R4";
            for (int m = 0; m < 4; m++) begin look(256, 1, m[1], m[0]); step(); end
        end
        // R3: same page under another identifier
        tag = "R3"; look(257, 2, 0, 0); step();
        fill(257, 2, 99, 15); step();
        look(257, 2, 0, 0); step(); look(257, 1, 0, 0); step();
        // R7: mark some entries referenced, then refill into a cold one
        tag = "R7";
        for (int i = 0; i < 10; i++) begin look(256 + i, 1, 0, 0); step(); end
        fill(600, 1, 5, 15); step();
        for (int i = 0; i < N; i++) begin look(256 + i, 1, 0, 0); step(); end
        // R8: everything referenced, refills go through the pointer
        tag = "R8";
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 60; i++) begin look(256 + (i % 45), 1, 0, 0); step(); end
            for (int i = 0; i < 3; i++) begin fill(700 + 3 * k + i, 1, 8, 15); step(); end
            for (int i = 0; i < 45; i++) begin look(256 + i, 1, 0, 0); step(); end
        end
        // R9: aging pulse alone and together with a hit
        tag = "R9";
        age_pulse = 1; step();
        look(260, 1, 0, 0); age_pulse = 1; step();
        fill(800, 1, 9, 15); step();
        for (int i = 0; i < 45; i++) begin look(256 + i, 1, 0, 0); step(); end
        // R10 and R6: restricted flush, refill into freed slots, full flush
        tag = "R10";
        flush_valid = 1; flush_by_asid = 1; flush_asid = 2; fill(900, 2, 1, 15); step();
        look(257, 2, 0, 0); step(); look(900, 2, 0, 0); step();
        tag = "R6";
        fill(901, 3, 2, 15); step(); look(901, 3, 0, 0); step();
        tag = "R10";
        flush_valid = 1; flush_by_asid = 0; step();
        for (int i = 0; i < 8; i++) begin look(256 + i, 1, 0, 0); step(); end
        // R5: mixed traffic on a small key space
        tag = "R5";
        for (int c = 0; c < 4000; c++) begin
            int op = $urandom_range(0, 99);
            if (op < 70) look($urandom_range(0, 63), $urandom_range(0, 3), 1'($urandom), 1'($urandom));
            if (op >= 50 && op < 80) fill($urandom_range(0, 63), $urandom_range(0, 3), $urandom_range(0, 9999), $urandom_range(0, 15));
            if (op == 80) begin flush_valid = 1; flush_by_asid = 1; flush_asid = 8'($urandom_range(0, 3)); end
            if (op == 81 && c % 7 == 0) begin flush_valid = 1; flush_by_asid = 0; end
            if (op >= 82 && op < 86) age_pulse = 1;
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule